// File: doc/BRIEF.md
# Start-Before-Error Precedence Monitor

This block is a synthesizable runtime checker that watches three single-bit signals of a design under observation. The first is a completion marker, the second a start marker and the third an error marker. Each time the completion marker is sampled high, the checker opens an obligation that begins on the following cycle. While the obligation is open, the start marker must be seen before the error marker is. A start marker alone discharges the obligation.

An error marker seen while the obligation is open is a violation. This holds even when the start marker arrives in the same cycle. A violation raises a one-cycle pulse and a sticky flag. The sticky flag holds until reset. A pending flag shows that an obligation is still open. An obligation that is still open when the run ends counts as pending and not as a failure. This is weak semantics.

The monitor sits next to the logic it observes. It samples everything on the rising edge of one clock and uses a synchronous, active-high reset. It keeps at most one obligation open at a time.

Top module: `order_guard`

## Requirements
- R1: While reset is sampled high, the pending flag, the failure pulse and the sticky failure flag are all 0 after that edge.
- R2: A completion marker sampled high makes the pending flag 1 after that edge. Start or error markers sampled on that same edge, with no obligation already open, have no effect.
- R3: While pending, a start marker with no error marker closes the obligation. No failure is reported, and the pending flag is 0 after that edge unless a completion marker is also sampled.
- R4: While pending, an error marker makes the failure pulse 1 for exactly the one cycle after that edge and closes the obligation. This holds whether or not the start marker is also high.
- R5: A completion marker sampled while an obligation is already open does not add a second one. A single start marker then leaves the pending flag at 0.
- R6: The sticky failure flag becomes 1 together with the first failure pulse and stays 1 until reset.
- R7: Start or error markers sampled while no obligation is open change none of the outputs.
- R8: A completion marker sampled on the same edge that closes an obligation opens a new obligation from the next cycle.
- R9: The obligation has no time limit. The pending flag stays 1 for as long as neither marker arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| done_i | input | 1 | Completion marker that opens an obligation |
| go_i | input | 1 | Start marker that discharges an open obligation |
| bad_i | input | 1 | Error marker that is a violation while an obligation is open |
| pending_o | output | 1 | An obligation is open |
| fail_pulse_o | output | 1 | One-cycle violation pulse |
| fail_sticky_o | output | 1 | Violation seen since reset |

## Verification
All state sits in three flops, so any wrong internal value shows at the ports one cycle after the edge that caused it. A lost or extra obligation appears on the pending flag at once. It then shows as a missing or spurious failure pulse on the first error marker that follows. A sticky flag that drops, or a pulse that lasts two cycles, shows on the next cycle. The bench therefore compares every output on every cycle against its own model of the obligation.

// File: rtl/order_guard_pkg.sv
package order_guard_pkg;

    typedef struct packed {
        logic open;
    } window_state_t;

    typedef struct packed {
        logic pulse;
        logic sticky;
    } verdict_state_t;

endpackage

// File: rtl/order_guard_window.sv
module order_guard_window
    import order_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic go_i,
    input  logic bad_i,
    output logic open_o,
    output logic viol_o
);

    window_state_t state_d;
    window_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.open && (go_i || bad_i)) begin
            state_d.open = 1'b0;
        end
        if (done_i) begin
            state_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign open_o = state_q.open;
    assign viol_o = state_q.open & bad_i;

endmodule

// File: rtl/order_guard_verdict.sv
module order_guard_verdict
    import order_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    output logic pulse_o,
    output logic sticky_o
);

    verdict_state_t state_d;
    verdict_state_t state_q;

    always_comb begin
        state_d        = state_q;
        state_d.pulse  = viol_i;
        if (viol_i) begin
            state_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse_o  = state_q.pulse;
    assign sticky_o = state_q.sticky;

endmodule

// File: rtl/order_guard.sv
module order_guard (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic go_i,
    input  logic bad_i,
    output logic pending_o,
    output logic fail_pulse_o,
    output logic fail_sticky_o
);

    logic viol;

    order_guard_window u_window (
        .clk    (clk),
        .rst    (rst),
        .done_i (done_i),
        .go_i   (go_i),
        .bad_i  (bad_i),
        .open_o (pending_o),
        .viol_o (viol)
    );

    order_guard_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .viol_i   (viol),
        .pulse_o  (fail_pulse_o),
        .sticky_o (fail_sticky_o)
    );

endmodule

// File: rtl/order_guard_chk.sv
module order_guard_chk (
    input logic clk,
    input logic rst,
    input logic done_i,
    input logic go_i,
    input logic bad_i,
    input logic pending_o,
    input logic fail_pulse_o,
    input logic fail_sticky_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pending_o && !fail_pulse_o && !fail_sticky_o));

    assert_arm_next_R2: assert property (@(posedge clk) disable iff (rst)
        done_i |=> pending_o);

    assert_discharge_R3: assert property (@(posedge clk) disable iff (rst)
        (pending_o && go_i && !bad_i && !done_i) |=> (!pending_o && !fail_pulse_o));

    assert_violation_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (pending_o && bad_i) |=> fail_pulse_o);

    assert_pulse_only_on_violation_R7: assert property (@(posedge clk) disable iff (rst)
        !(pending_o && bad_i) |=> !fail_pulse_o);

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (rst)
        fail_sticky_o |=> fail_sticky_o);

    assert_pulse_sets_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        fail_pulse_o |-> fail_sticky_o);

    assert_no_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !go_i && !bad_i) |=> pending_o);

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (!pending_o && !done_i) |=> !pending_o);

endmodule

bind order_guard order_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .done_i        (done_i),
    .go_i          (go_i),
    .bad_i         (bad_i),
    .pending_o     (pending_o),
    .fail_pulse_o  (fail_pulse_o),
    .fail_sticky_o (fail_sticky_o)
);

// File: tb/order_guard_tb.sv
module order_guard_tb;

    logic clk = 1'b0;
    logic rst;
    logic done_i, go_i, bad_i;
    logic pending_o, fail_pulse_o, fail_sticky_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference: number of open obligations and violation tally
    int open_cnt  = 0;
    int viol_seen = 0;
    bit exp_pulse = 0;

    always #5 clk = ~clk;

    order_guard u_dut (
        .clk           (clk),
        .rst           (rst),
        .done_i        (done_i),
        .go_i          (go_i),
        .bad_i         (bad_i),
        .pending_o     (pending_o),
        .fail_pulse_o  (fail_pulse_o),
        .fail_sticky_o (fail_sticky_o)
    );

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check_bit({tag, " pending"}, pending_o, open_cnt > 0);
        check_bit({tag, " pulse"}, fail_pulse_o, exp_pulse);
        check_bit({tag, " sticky"}, fail_sticky_o, viol_seen > 0);
    endtask

    task automatic step(string tag, bit d, bit g, bit b);
        done_i = d; go_i = g; bad_i = b;
        @(posedge clk);
        exp_pulse = 0;
        if (open_cnt > 0) begin
            if (b) begin
                exp_pulse = 1;
                viol_seen++;
                open_cnt = 0;
            end else if (g) begin
                open_cnt = 0;
            end
        end
        if (d) open_cnt = 1;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; done_i = 0; go_i = 0; bad_i = 0;
        @(posedge clk);
        @(negedge clk);
        open_cnt = 0; viol_seen = 0; exp_pulse = 0;
        compare("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; done_i = 0; go_i = 0; bad_i = 0;
        @(negedge clk);
        do_reset();

        // R3: clean discharge
        step("R2 arm", 1, 0, 0);
        step("R3 go", 0, 1, 0);
        step("R3 idle", 0, 0, 0);

        // R2: markers on the arming edge are ignored
        step("R2 arm with go+bad", 1, 1, 1);
        step("R3 go after arm", 0, 1, 0);

        // R7: markers outside a window
        step("R7 bad idle", 0, 0, 1);
        step("R7 go idle", 0, 1, 0);
        step("R7 both idle", 0, 1, 1);

        // R9: long window
        step("R2 arm long", 1, 0, 0);
        for (int i = 0; i < 40; i++) step("R9 wait", 0, 0, 0);
        step("R3 late go", 0, 1, 0);

        // R5: repeated completion markers
        step("R5 arm", 1, 0, 0);
        step("R5 re-arm", 1, 0, 0);
        step("R5 re-arm", 1, 0, 0);
        step("R5 single go", 0, 1, 0);
        step("R5 idle", 0, 0, 0);

        // R8: close and re-open on same edge
        step("R8 arm", 1, 0, 0);
        step("R8 go+done", 1, 1, 0);
        step("R8 go", 0, 1, 0);

        // R4: error before start
        step("R4 arm", 1, 0, 0);
        step("R4 wait", 0, 0, 0);
        step("R4 bad", 0, 0, 1);
        step("R4 pulse ends", 0, 0, 0);
        step("R7 go after fail", 0, 1, 0);

        // R4: error and start together, with R8 re-open on bad
        step("R4 arm2", 1, 0, 0);
        step("R4 go+bad", 1, 1, 1);
        step("R4 bad again", 0, 0, 1);
        step("R6 hold", 0, 0, 0);
        for (int i = 0; i < 5; i++) step("R6 sticky hold", 0, 0, 0);

        // R1: reset clears sticky
        do_reset();
        step("R1 after reset", 0, 0, 1);

        // weak semantics: leave an obligation open
        step("R2 final arm", 1, 0, 0);
        step("R9 final wait", 0, 0, 0);
        if (pending_o) $display("INFO obligation pending at end of run (not a failure)");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule